// File: doc/BRIEF.md
# Debug System Bus Access Engine

This block lets an external debugger read and write 32-bit words on a simple memory bus through three debug registers: a control/status word, an address register and a data register. Register accesses start bus transactions directly. A write to the data register stores a word at the current address. If the matching mode bits are set, a write to the address register fetches that word. With another mode bit, a read of the data register returns the word already held and then fetches the next one.

With auto-increment on, the address advances by one word after each bus access completes. Block transfers therefore need only one register access per word. A busy bit shows when a bus transaction is outstanding. A register access that would start a second transaction while one is in flight is dropped, and a sticky error bit records it. Software clears the error bit by writing 1 to it.

The register port takes one access per cycle, qualified by a request strobe. Register reads return data in the same cycle. The memory side holds its request until it sees a grant. It then waits for a response-valid pulse, which completes both reads and writes.

Top module: `sba_engine`

## Requirements
- R1: After reset the control word reads 0x40 (size field bits 7:5 = 2, all other bits 0), the address and data registers read 0, and no bus request is raised.
- R2: With the read-on-address bit (bit 2) set, writing the address register starts a bus read of that address, and the returned word is then held in the data register.
- R3: Writing the data register (register index 2) starts a bus write of the written value to the current address.
- R4: With the read-on-data bit (bit 3) set, a data register read returns the held word and then starts a bus read of the current address.
- R5: With the read-on-data bit clear, a data register read returns the last fetched word and starts no bus access.
- R6: With the auto-increment bit (bit 4) set, the address register grows by 4 after each bus access completes. With the bit clear, the address register is unchanged.
- R7: The busy bit (bit 0) reads 1 from the cycle after a launch until the response arrives. While the request is waiting for a grant, the bus request, address and write data are held steady.
- R8: An address write, a data write, or a launching data read made while busy sets the error bit (bit 1). The access is dropped: no register changes and no extra bus transaction starts.
- R9: The error bit stays set until a control write with bit 1 = 1 clears it. A control write with bit 1 = 0 leaves it set.
- R10: When the size field is not 2, an access that would start a transaction starts none and sets the error bit.
- R11: With the read-on-address bit clear, an address write only loads the address and starts no bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register index: 0 control, 1 address, 2 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the same cycle |
| bus_req | output | 1 | Bus request, held until granted |
| bus_we | output | 1 | Bus transaction is a write |
| bus_addr | output | 32 | Bus byte address |
| bus_wdata | output | 32 | Bus write data |
| bus_gnt | input | 1 | Bus grant |
| bus_rvalid | input | 1 | Bus response; ends reads and writes |
| bus_rdata | input | 32 | Bus read data |

## Verification
The bench sweeps every pairing of grant delay and response delay from 0 to 2 cycles. In each pairing it streams a block read and checks each returned word against an address-derived pattern. A design that returns a word before fetching, or increments before completion, would show each value one word out of step, and the final address would be off by four. In every sweep it also writes the address register while busy. A design that does not drop that write would corrupt the address in flight or issue an extra transaction. Further checks cover the error bit surviving a zero write, a size field other than 2 blocking launches, and non-prefetching reads leaving the bus idle.

// File: rtl/sba_pkg.sv
package sba_pkg;
  localparam int CTL_BUSY    = 0;
  localparam int CTL_ERR     = 1;
  localparam int CTL_RDADDR  = 2;
  localparam int CTL_RDDATA  = 3;
  localparam int CTL_INC     = 4;
  localparam int CTL_SIZE_LO = 5;
  localparam int SIZE_W      = 3;
  localparam logic [SIZE_W-1:0] SIZE_WORD = 3'd2;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_ADDR = 2'd1,
    REG_DATA = 2'd2
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } bus_st_e;

  typedef struct packed {
    logic [SIZE_W-1:0] size;
    logic              inc;
    logic              rd_data;
    logic              rd_addr;
  } cfg_t;
endpackage

// File: rtl/sba_csr.sv
module sba_csr
  import sba_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       err_set,
  output cfg_t       cfg_o,
  output logic       err_o
);
  cfg_t cfg_q, cfg_d;
  logic err_q, err_d;

  always_comb begin
    cfg_d = cfg_q;
    err_d = err_q;
    if (wr_en) begin
      cfg_d.size    = wdata[CTL_SIZE_LO +: SIZE_W];
      cfg_d.inc     = wdata[CTL_INC];
      cfg_d.rd_data = wdata[CTL_RDDATA];
      cfg_d.rd_addr = wdata[CTL_RDADDR];
      if (wdata[CTL_ERR]) err_d = 1'b0;
    end
    if (err_set) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{size: SIZE_WORD, inc: 1'b0, rd_data: 1'b0, rd_addr: 1'b0};
      err_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  assign cfg_o = cfg_q;
  assign err_o = err_q;

  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[CTL_ERR] && !err_set) |=> !err_q);
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(wr_en && wdata[CTL_ERR])) |=> err_q);
endmodule

// File: rtl/sba_addr.sv
module sba_addr #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = load | inc;
    addr_d  = load ? load_val : (addr_q + STEP_V);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> (addr_q == $past(addr_q) + STEP_V));
endmodule

// File: rtl/sba_master.sv
module sba_master
  import sba_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_we,
  input  logic              data_load,
  input  logic [DATA_W-1:0] data_in,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_rvalid,
  input  logic [DATA_W-1:0] bus_rdata
);
  bus_st_e           st_q, st_d;
  logic              we_q;
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_en, done;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start)      st_d = ST_REQ;
      ST_REQ:  if (bus_gnt)    st_d = ST_WAIT;
      ST_WAIT: if (bus_rvalid) st_d = ST_IDLE;
      default:                 st_d = ST_IDLE;
    endcase
    done    = (st_q == ST_WAIT) && bus_rvalid;
    data_en = data_load | (done & ~we_q);
    data_d  = data_load ? data_in : bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      we_q   <= 1'b0;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      if (start)   we_q   <= start_we;
      if (data_en) data_q <= data_d;
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done;
  assign data_o    = data_q;
  assign bus_req   = (st_q == ST_REQ);
  assign bus_we    = we_q;
  assign bus_addr  = addr_i;
  assign bus_wdata = data_q;

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) &&
                               $stable(bus_wdata) && $stable(bus_we)));
  p_no_rsp_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done) |=> !bus_req);
endmodule

// File: rtl/sba_engine.sv
module sba_engine
  import sba_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_rvalid,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int STEP = DATA_W / 8;

  logic [1:0]        rst_sync_q;
  logic              rst_ns;
  cfg_t              cfg;
  logic              err, busy, done;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic              wr_ctrl, wr_addr, wr_data, rd_data;
  logic              want_rd_data, want, collide, size_ok, bad_size;
  logic              start, err_set, addr_load, data_load, inc;
  logic [7:0]        ctrl_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  always_comb begin
    wr_ctrl      = reg_req &  reg_we & (reg_addr == REG_CTRL);
    wr_addr      = reg_req &  reg_we & (reg_addr == REG_ADDR);
    wr_data      = reg_req &  reg_we & (reg_addr == REG_DATA);
    rd_data      = reg_req & ~reg_we & (reg_addr == REG_DATA);
    want_rd_data = rd_data & cfg.rd_data;
    want         = (wr_addr & cfg.rd_addr) | wr_data | want_rd_data;
    size_ok      = (cfg.size == SIZE_WORD);
    collide      = busy & (wr_addr | wr_data | want_rd_data);
    bad_size     = ~busy & want & ~size_ok;
    err_set      = collide | bad_size;
    start        = ~busy & want & size_ok;
    addr_load    = ~busy & wr_addr;
    data_load    = ~busy & wr_data;
    inc          = done & cfg.inc;
    ctrl_word    = {cfg.size, cfg.inc, cfg.rd_data, cfg.rd_addr, err, busy};
    unique case (reg_addr)
      REG_CTRL: reg_rdata = DATA_W'(ctrl_word);
      REG_ADDR: reg_rdata = DATA_W'(addr);
      REG_DATA: reg_rdata = data;
      default:  reg_rdata = '0;
    endcase
  end

  sba_csr u_csr (
    .clk(clk), .rst_n(rst_ns), .wr_en(wr_ctrl), .wdata(reg_wdata[7:0]),
    .err_set(err_set), .cfg_o(cfg), .err_o(err)
  );

  sba_addr #(.ADDR_W(ADDR_W), .STEP(STEP)) u_addr (
    .clk(clk), .rst_n(rst_ns), .load(addr_load),
    .load_val(ADDR_W'(reg_wdata)), .inc(inc), .addr_o(addr)
  );

  sba_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_master (
    .clk(clk), .rst_n(rst_ns), .start(start), .start_we(wr_data),
    .data_load(data_load), .data_in(reg_wdata), .addr_i(addr),
    .busy_o(busy), .done_o(done), .data_o(data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata)
  );

  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    start |=> busy);
  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy && !done && (wr_addr || wr_data)) |=> (err && $stable(addr)));
  p_quiet_read_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_data && !cfg.rd_data && !busy) |=> !busy);
  p_size_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    (want && !size_ok && !busy) |=> (!busy && err));
endmodule

// File: tb/sba_engine_bench.sv
module sba_engine_bench;
  logic        clk, rst_n;
  logic        reg_req, reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        bus_req, bus_we, bus_gnt, bus_rvalid;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;

  int tests, fails, txn, gnt_dly, rsp_dly, phase, gcnt, rcnt;
  logic [31:0] l_addr, l_wdata;
  logic        l_we;

  sba_engine u_sba_engine (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h0F0F_1234;
  endfunction

  // bus responder: decisions at the falling edge
  always @(negedge clk) begin
    bus_gnt    = 1'b0;
    bus_rvalid = 1'b0;
    if (!rst_n) begin
      phase = 0; gcnt = 0; rcnt = 0;
    end else if (phase == 0) begin
      if (bus_req) begin
        if (gcnt >= gnt_dly) begin
          bus_gnt = 1'b1; l_addr = bus_addr; l_we = bus_we; l_wdata = bus_wdata;
          txn++; gcnt = 0; rcnt = 0; phase = 1;
        end else gcnt++;
      end
    end else begin
      if (rcnt >= rsp_dly) begin
        bus_rvalid = 1'b1;
        bus_rdata  = l_we ? 32'h0 : memf(l_addr);
        phase = 0;
      end else rcnt++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_req = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
    #2 d = reg_rdata;
    @(posedge clk); #1;
    reg_req = 1'b0;
  endtask

  task automatic wait_idle;
    logic [31:0] c;
    for (int i = 0; i < 40; i++) begin
      rd(2'd0, c);
      if (!c[0]) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, c, base;
    int t0;
    tests = 0; fails = 0; txn = 0; gnt_dly = 0; rsp_dly = 0;
    reg_req = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    bus_gnt = 0; bus_rvalid = 0; bus_rdata = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", d, 32'h40);
    rd(2'd1, d); check("R1 addr", d, 32'h0);
    check("R1 bus_req", {31'b0, bus_req}, 32'h0);
    rd(2'd2, d); check("R1 data", d, 32'h0);

    // R11 address write without read-on-address
    wr(2'd1, 32'h1000);
    repeat (5) @(negedge clk);
    check("R11 no txn", txn, 0);
    rd(2'd1, d); check("R11 addr", d, 32'h1000);

    // sweep grant and response delays
    for (int g = 0; g < 3; g++) begin
      for (int r = 0; r < 3; r++) begin
        gnt_dly = g; rsp_dly = r;
        base = 32'h2000_0000 + 32'(g * 3 + r) * 32'h100;
        wr(2'd0, 32'h5E);              // size 2, inc, rd_data, rd_addr, clear err
        t0 = txn;
        wr(2'd1, base);                // R2 launch
        rd(2'd0, c); check("R7 busy", {31'b0, c[0]}, 32'h1);
        wr(2'd1, 32'hDEAD_0000);       // R8 collision
        wait_idle();
        check("R8 single txn", txn, t0 + 1);
        rd(2'd0, c); check("R8 err", {31'b0, c[1]}, 32'h1);
        rd(2'd1, d); check("R8/R6 addr", d, base + 32'd4);
        wr(2'd0, 32'h5C);
        rd(2'd0, c); check("R9 kept", {31'b0, c[1]}, 32'h1);
        wr(2'd0, 32'h5E);
        rd(2'd0, c); check("R9 cleared", c, 32'h5C);
        for (int i = 0; i < 4; i++) begin
          rd(2'd2, d);
          check(i == 0 ? "R2 fetched" : "R4 stream", d, memf(base + 32'(4 * i)));
          wait_idle();
        end
        check("R4 txn count", txn, t0 + 5);
        rd(2'd1, d); check("R6 final addr", d, base + 32'd20);
        wr(2'd0, 32'h54);
        t0 = txn;
        rd(2'd2, d); check("R5 held", d, memf(base + 32'd16));
        repeat (4) @(negedge clk);
        check("R5 no txn", txn, t0);
      end
    end

    // R3 writes with auto-increment
    gnt_dly = 1; rsp_dly = 1;
    wr(2'd0, 32'h50);
    wr(2'd1, 32'h3000);
    for (int i = 0; i < 3; i++) begin
      wr(2'd2, 32'hC0DE_0000 + 32'(i));
      wait_idle();
      check("R3 we", {31'b0, l_we}, 32'h1);
      check("R3 addr", l_addr, 32'h3000 + 32'(4 * i));
      check("R3 wdata", l_wdata, 32'hC0DE_0000 + 32'(i));
    end
    rd(2'd1, d); check("R6 after writes", d, 32'h300C);
    wr(2'd0, 32'h40);
    wr(2'd2, 32'h1234_5678);
    wait_idle();
    rd(2'd1, d); check("R6 no inc", d, 32'h300C);
    check("R3 addr noinc", l_addr, 32'h300C);

    // R8 data write while busy
    t0 = txn;
    wr(2'd2, 32'hAAAA_0001);
    wr(2'd2, 32'hBBBB_0002);
    wait_idle();
    check("R8 data txn", txn, t0 + 1);
    check("R8 data kept", l_wdata, 32'hAAAA_0001);
    rd(2'd2, d); check("R8 data reg", d, 32'hAAAA_0001);
    rd(2'd0, c); check("R8 data err", {31'b0, c[1]}, 32'h1);
    wr(2'd0, 32'h42);

    // R10 size not 2
    wr(2'd0, 32'h2C);
    t0 = txn;
    wr(2'd2, 32'h5);
    wr(2'd1, 32'h4000);
    rd(2'd2, d);
    repeat (4) @(negedge clk);
    check("R10 no txn", txn, t0);
    rd(2'd0, c); check("R10 err", c, 32'h2E);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule